// File: doc/BRIEF.md
# Indirect-Indexed Codec Register Bank

This block is the control register file of a simple audio codec, seen by a host through a 64-byte window on a 32-bit bus. The window holds sixteen word-wide direct registers, selected by byte address bits [5:2]. Two of them form an indirect access path into a second bank of thirty-two byte-wide registers. Direct word 0 holds a pointer, and its low five bits choose an indirect entry. Direct word 1 is the data port for that entry.

Most entries behave as plain storage, but a few do not. One indirect entry reads as zero, two ignore writes, and one merges the written data with a fixed identifier. Among the direct words, one is read-only, and the control word can clear and reload the whole bank in the same cycle as the write. The interrupt output is present for pin compatibility and is held low.

Top module: `codec_regbank`

## Requirements
- R1: A read (bus_valid=1, bus_write=0) drives bus_rdata on the first rising edge after the strobe. bus_rdata holds its value through idle cycles and writes until the next read.
- R2: Direct word 0 stores and returns all 32 written bits. The indirect pointer is bits [4:0] of word 0, and bits [31:5] do not affect which entry is selected.
- R3: A read of direct word 1 returns the indirect entry selected by the pointer, zero-extended to 32 bits. A write to word 1 stores bus_wdata[7:0] into that entry, apart from the entries named in R4 to R6.
- R4: Indirect entry 3 is write-only, so a read of it through word 1 always returns 0.
- R5: Indirect entries 11 and 25 ignore writes through word 1 and keep their current value.
- R6: A write through word 1 to indirect entry 12 stores (bus_wdata[7:0] & 8'h40) | 8'h8A.
- R7: After reset, every direct word reads 0 and every indirect entry reads 0, except entry 12, which reads 8'h8A, and entry 25, which reads 8'hA0.
- R8: Direct word 2 ignores writes and always reads 0.
- R9: A write to direct word 4 stores bus_wdata & 32'h7F in word 4. If bus_wdata[0] is 1, the same edge also returns every other direct word and every indirect entry to its R7 reset value.
- R10: Direct words 3 and 5 to 15 store and return the full 32-bit written word.
- R11: irq is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read; sampled with bus_valid |
| bus_addr | input | 6 | Byte address in the window; bits [5:2] select the direct word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, held at 0 |

## Verification
A write takes effect on the rising edge at the end of its strobe cycle, so the next access already sees the new state. This includes the bank-wide clear caused by the control word. Read data is due at the next rising edge after the read strobe.

The bench drives each access on a falling edge and removes the strobe at the following falling edge. It compares bus_rdata at that moment, which is half a cycle after the capture edge. To check that bus_rdata holds, the bench samples it again after idle cycles and after intervening writes, and compares it with the value captured earlier.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;

    // Geometry of the window and of the two banks
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int N_DIRECT   = 16;
    localparam int N_INDIRECT = 32;
    localparam int ADDR_W     = 6;
    localparam int SEL_W      = $clog2(N_DIRECT);
    localparam int IDX_W      = $clog2(N_INDIRECT);

    // Direct words with special behaviour
    localparam int DW_POINTER = 0;
    localparam int DW_PORT    = 1;
    localparam int DW_LOCKED  = 2;
    localparam int DW_CONTROL = 4;
    localparam int CTRL_KEEP_W = 7;
    localparam int CTRL_CLEAR_BIT = 0;

    // Indirect entries with special behaviour
    localparam int IX_WRITE_ONLY = 3;
    localparam int IX_FROZEN_A   = 11;
    localparam int IX_MERGED     = 12;
    localparam int IX_FROZEN_B   = 25;

    localparam logic [BYTE_W-1:0] CODEC_ID   = 8'h8A;
    localparam logic [BYTE_W-1:0] CHIP_ID    = 8'hA0;
    localparam logic [BYTE_W-1:0] MERGE_KEEP = 8'h40;

    // Decoded bus operation
    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [SEL_W-1:0] sel;
        logic             to_port;
        logic             to_control;
    } bus_op_t;

endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import codec_regbank_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int SW   = SEL_W,
    parameter int PORT = DW_PORT,
    parameter int CTRL = DW_CONTROL
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    output bus_op_t       op
);

    logic unused_byte_lane;
    assign unused_byte_lane = ^addr[1:0];

    always_comb begin
        op            = '0;
        op.rd         = valid && !write;
        op.wr         = valid && write;
        op.sel        = addr[AW-1:2];
        op.to_port    = (addr[AW-1:2] == SW'(PORT));
        op.to_control = (addr[AW-1:2] == SW'(CTRL));
    end

endmodule

// File: rtl/crb_direct_bank.sv
module crb_direct_bank #(
    parameter int N        = 16,
    parameter int W        = 32,
    parameter int SW       = 4,
    parameter int PORT     = 1,
    parameter int LOCKED   = 2,
    parameter int CTRL     = 4,
    parameter int CTRL_KW  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SW-1:0]       sel,
    input  logic [W-1:0]        wdata,
    input  logic                clear,
    output logic [N-1:0][W-1:0] words
);

    localparam logic [W-1:0] CTRL_MASK = W'((64'd1 << CTRL_KW) - 64'd1);

    typedef struct packed {
        logic [N-1:0][W-1:0] w;
    } dir_state_t;

    dir_state_t st_d, st_q;

    // Per-word write policy chosen at elaboration
    logic [W-1:0] keep_mask [N];
    logic         storable  [N];

    for (genvar g = 0; g < N; g++) begin : g_policy
        if (g == LOCKED || g == PORT) begin : g_none
            assign keep_mask[g] = '0;
            assign storable[g]  = 1'b0;
        end else if (g == CTRL) begin : g_ctrl
            assign keep_mask[g] = CTRL_MASK;
            assign storable[g]  = 1'b1;
        end else begin : g_full
            assign keep_mask[g] = '1;
            assign storable[g]  = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.w = '0;
        end
        if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (sel == SW'(i) && storable[i]) begin
                    st_d.w[i] = wdata & keep_mask[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.w;

endmodule

// File: rtl/crb_indirect_bank.sv
module crb_indirect_bank #(
    parameter int          N         = 32,
    parameter int          B         = 8,
    parameter int          IW        = 5,
    parameter int          WONLY     = 3,
    parameter int          FROZEN_A  = 11,
    parameter int          FROZEN_B  = 25,
    parameter int          MERGED    = 12,
    parameter logic [B-1:0] FIXED_ID = 8'h8A,
    parameter logic [B-1:0] KEEP     = 8'h40,
    parameter logic [B-1:0] FROZEN_B_VAL = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [B-1:0]  wdata,
    output logic [B-1:0]  rdata
);

    typedef struct packed {
        logic [N-1:0][B-1:0] e;
    } ind_state_t;

    ind_state_t st_d, st_q;

    logic [B-1:0] init_val [N];
    logic         accepts  [N];
    logic         visible  [N];
    logic         merges   [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        if (g == MERGED) begin : g_init_id
            assign init_val[g] = FIXED_ID;
        end else if (g == FROZEN_B) begin : g_init_chip
            assign init_val[g] = FROZEN_B_VAL;
        end else begin : g_init_zero
            assign init_val[g] = '0;
        end
        assign accepts[g] = (g != FROZEN_A) && (g != FROZEN_B);
        assign visible[g] = (g != WONLY);
        assign merges[g]  = (g == MERGED);
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            for (int i = 0; i < N; i++) begin
                st_d.e[i] = init_val[i];
            end
        end
        if (wr_en && accepts[idx]) begin
            if (merges[idx]) begin
                st_d.e[idx] = (wdata & KEEP) | FIXED_ID;
            end else begin
                st_d.e[idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st_q.e[i] <= init_val[i];
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = visible[idx] ? st_q.e[idx] : '0;

endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import codec_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    bus_op_t                          op;
    logic [N_DIRECT-1:0][WORD_W-1:0]  dir_words;
    logic [IDX_W-1:0]                 ind_index;
    logic [BYTE_W-1:0]                ind_byte;
    logic                             bank_clear;
    logic                             dir_wr;
    logic                             ind_wr;

    crb_decode #(
        .AW   (ADDR_W),
        .SW   (SEL_W),
        .PORT (DW_PORT),
        .CTRL (DW_CONTROL)
    ) u_decode (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .op    (op)
    );

    assign bank_clear = op.wr && op.to_control && bus_wdata[CTRL_CLEAR_BIT];
    assign dir_wr     = op.wr && !op.to_port;
    assign ind_wr     = op.wr && op.to_port;
    assign ind_index  = dir_words[DW_POINTER][IDX_W-1:0];

    crb_direct_bank #(
        .N       (N_DIRECT),
        .W       (WORD_W),
        .SW      (SEL_W),
        .PORT    (DW_PORT),
        .LOCKED  (DW_LOCKED),
        .CTRL    (DW_CONTROL),
        .CTRL_KW (CTRL_KEEP_W)
    ) u_direct (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dir_wr),
        .sel   (op.sel),
        .wdata (bus_wdata),
        .clear (bank_clear),
        .words (dir_words)
    );

    crb_indirect_bank #(
        .N            (N_INDIRECT),
        .B            (BYTE_W),
        .IW           (IDX_W),
        .WONLY        (IX_WRITE_ONLY),
        .FROZEN_A     (IX_FROZEN_A),
        .FROZEN_B     (IX_FROZEN_B),
        .MERGED       (IX_MERGED),
        .FIXED_ID     (CODEC_ID),
        .KEEP         (MERGE_KEEP),
        .FROZEN_B_VAL (CHIP_ID)
    ) u_indirect (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (bank_clear),
        .wr_en (ind_wr),
        .idx   (ind_index),
        .wdata (bus_wdata[BYTE_W-1:0]),
        .rdata (ind_byte)
    );

    always_comb begin
        st_d = st_q;
        if (op.rd) begin
            if (op.to_port) begin
                st_d.rdata = {{(WORD_W-BYTE_W){1'b0}}, ind_byte};
            end else begin
                st_d.rdata = dir_words[op.sel];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = 1'b0;

endmodule

// File: rtl/codec_regbank_chk.sv
module codec_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic [4:0]  ind_index
);

    logic unused_chk;
    assign unused_chk = ^{bus_addr[1:0], bus_wdata[31:5]};

    logic is_read, is_write;
    assign is_read  = bus_valid && !bus_write;
    assign is_write = bus_valid && bus_write;

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == 1'b0);

    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(bus_rdata));

    assert_pointer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && bus_addr[5:2] == 4'd0) |=> ind_index == $past(bus_wdata[4:0]));

    assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && bus_addr[5:2] == 4'd1 && ind_index == 5'd3) |=> bus_rdata == 32'd0);

    assert_frozen_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && bus_addr[5:2] == 4'd1 && ind_index == 5'd25) |=> bus_rdata == 32'h0000_00A0);

    assert_merged_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && bus_addr[5:2] == 4'd1 && ind_index == 5'd12)
        |=> (bus_rdata & 32'hFFFF_FFBF) == 32'h0000_008A);

    assert_locked_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && bus_addr[5:2] == 4'd2) |=> bus_rdata == 32'd0);

    assert_clear_pointer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && bus_addr[5:2] == 4'd4 && bus_wdata[0]) |=> ind_index == 5'd0);

endmodule

bind codec_regbank codec_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ind_index (ind_index)
);

// File: tb/codec_regbank_tb.sv
module codec_regbank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid;
    logic        bus_write;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_dir [16];
    logic [7:0]  m_ind [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_regbank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic void m_reset();
        for (int i = 0; i < 16; i++) m_dir[i] = 32'd0;
        for (int i = 0; i < 32; i++) m_ind[i] = 8'd0;
        m_ind[12] = 8'h8A;
        m_ind[25] = 8'hA0;
    endfunction

    function automatic void m_write(int w, logic [31:0] d);
        int idx;
        idx = int'(m_dir[0][4:0]);
        if (w == 1) begin
            if (idx == 12)                  m_ind[idx] = (d[7:0] & 8'h40) | 8'h8A;
            else if (idx != 11 && idx != 25) m_ind[idx] = d[7:0];
        end else if (w == 4) begin
            if (d[0]) m_reset();
            m_dir[4] = d & 32'h7F;
        end else if (w != 2) begin
            m_dir[w] = d;
        end
    endfunction

    function automatic logic [31:0] m_read(int w);
        int idx;
        idx = int'(m_dir[0][4:0]);
        if (w == 1) return (idx == 3) ? 32'd0 : {24'd0, m_ind[idx]};
        if (w == 2) return 32'd0;
        return m_dir[w];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int w, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = {w[3:0], 2'($urandom % 4)};
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wdata = $urandom;
        m_write(w, d);
    endtask

    task automatic rd_chk(int w, string req);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = {w[3:0], 2'($urandom % 4)};
        @(negedge clk);
        bus_valid = 1'b0;
        check(req, bus_rdata, m_read(w));
        check("R11", {31'd0, irq}, 32'd0);
    endtask

    task automatic set_idx(int i);
        logic [31:0] v;
        v = $urandom;
        v[4:0] = i[4:0];
        wr(0, v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr = '0;
        bus_wdata = '0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents of both banks
        check("R1", bus_rdata, 32'd0);
        for (int w = 0; w < 16; w++) rd_chk(w, "R7");
        for (int i = 0; i < 32; i++) begin
            set_idx(i);
            rd_chk(1, "R7");
        end

        // R2: pointer word stores all bits, only low five select
        wr(0, 32'hFFFF_FFE5);
        rd_chk(0, "R2");
        wr(1, 32'h1234_56C3);
        rd_chk(1, "R3");
        set_idx(5);
        rd_chk(1, "R2");

        // R4: write-only entry
        set_idx(3);
        wr(1, 32'h55);
        rd_chk(1, "R4");

        // R5: frozen entries
        set_idx(11);
        wr(1, 32'hFF);
        rd_chk(1, "R5");
        set_idx(25);
        wr(1, 32'h3C);
        rd_chk(1, "R5");

        // R6: merged identifier entry
        set_idx(12);
        wr(1, 32'hFFFF_FFFF);
        rd_chk(1, "R6");
        wr(1, 32'h0000_00BF);
        rd_chk(1, "R6");

        // R8: locked word
        wr(2, 32'hDEAD_BEEF);
        rd_chk(2, "R8");

        // R10: plain words
        for (int w = 3; w < 16; w++) begin
            if (w != 4) begin
                wr(w, $urandom);
                rd_chk(w, "R10");
            end
        end

        // R9: control word without and with bank clear
        wr(4, 32'hFFFF_FF02);
        rd_chk(4, "R9");
        rd_chk(5, "R9");
        set_idx(7);
        wr(1, 32'h77);
        wr(4, 32'hFFFF_FF81);
        rd_chk(4, "R9");
        rd_chk(0, "R9");
        rd_chk(5, "R9");
        rd_chk(1, "R9");
        set_idx(12);
        rd_chk(1, "R9");
        set_idx(25);
        rd_chk(1, "R9");

        // R1: read data held across idle cycles and writes
        wr(9, 32'hCAFE_F00D);
        rd_chk(9, "R1");
        held = bus_rdata;
        repeat (3) @(negedge clk);
        check("R1", bus_rdata, held);
        wr(9, 32'h0BAD_0BAD);
        wr(1, 32'h11);
        check("R1", bus_rdata, held);

        // Random mix
        for (int k = 0; k < 800; k++) begin
            automatic int w;
            automatic logic [31:0] d;
            w = int'($urandom % 16);
            d = $urandom;
            if (w == 4 && ($urandom % 6) != 0) d[0] = 1'b0;
            if ($urandom % 2) begin
                wr(w, d);
            end else begin
                case (w)
                    0:       rd_chk(w, "R2");
                    1:       rd_chk(w, "R3");
                    2:       rd_chk(w, "R8");
                    4:       rd_chk(w, "R9");
                    default: rd_chk(w, "R10");
                endcase
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule